// File: doc/BRIEF.md
# Mode-Selectable Parallel Port Byte FIFO

This block is the byte FIFO that sits behind the data port of a host-side parallel port controller. A 3-bit mode register and a direction bit in a small control register decide who fills the FIFO and who drains it. In test mode the host both writes and reads the FIFO, and the peripheral side stays idle. In compatibility mode the host writes bytes and a valid/ready port interface drains them toward the peripheral. In ECP data mode the same forward path applies with direction 0. With direction 1 the port interface fills the FIFO and the host reads the bytes out.

The block reports full and empty flags. It raises a service flag when enough space is free, or when enough data is waiting, depending on the effective direction. It also produces a one-cycle interrupt pulse on each low-to-high edge of the acknowledge input. Writing the mode register always empties the FIFO and clears the saved last-read byte.

Top module: `ppModeFifo`

## Requirements
- R1: After reset the FIFO is empty, full is low, the mode reads 000, the control register reads 0x00 and the service flag is high, because the direction is output and 16 entries are free.
- R2: With mode 3'b110 (test mode) the host writes push bytes and the host reads pop them in first-in first-out order, whatever the direction bit is.
- R3: In test mode a host write to a full FIFO is discarded, and the stored contents and their order stay unchanged.
- R4: In test mode a host read from an empty FIFO returns the byte that the last successful host read returned, and the read position does not move.
- R5: `fifoFull` is high exactly when 16 bytes are held and `fifoEmpty` is high exactly when none are held. This holds after discarded writes and repeated reads too.
- R6: The effective direction `dirIn` is 0 in modes 000 and 010 whatever the value of control bit 5. In all other modes `dirIn` equals control bit 5, where 1 means input.
- R7: In test mode `portTxValid` and `portRxReady` stay low. `portTxData` shows the byte at the head of the FIFO.
- R8: In mode 3'b010 (compatibility) `portTxValid` is high while the FIFO is not empty, and the head byte is removed in each cycle where `portTxReady` is high. Host reads and port-side input bytes have no effect.
- R9: In mode 3'b011 (ECP data) with `dirIn`=0 the port drains the FIFO as in R8. With `dirIn`=1, `portRxReady` is high while the FIFO is not full. Accepted port bytes are queued and host reads pop them in order, and host writes are ignored.
- R10: `serviceIntr` is high when free entries are at least 8 while `dirIn`=0, or when held entries are at least 8 while `dirIn`=1.
- R11: A low-to-high transition on `ackIn` produces `ackIntr` high for exactly one cycle, in the cycle after the edge is sampled.
- R12: Control bits 7 and 6 always read 0. Bits 5..0 read back what was written.
- R13: Any write to the mode register empties the FIFO and resets the saved last-read byte to 0x00. A test-mode read from the empty FIFO right after such a write returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Mode register write strobe |
| modeWrData | input | 3 | New mode value |
| modeRdData | output | 3 | Current mode |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWrData | input | 8 | Control write value (bit 5 = direction) |
| ctlRdData | output | 8 | Control register readback |
| hostWrEn | input | 1 | Host data write strobe |
| hostWrData | input | 8 | Host data byte |
| hostRdEn | input | 1 | Host data read strobe |
| hostRdData | output | 8 | Byte a host read in this cycle returns |
| portTxValid | output | 1 | Byte offered toward the peripheral |
| portTxData | output | 8 | FIFO head byte |
| portTxReady | input | 1 | Peripheral side accepts the head byte |
| portRxValid | input | 1 | Peripheral side offers a byte |
| portRxData | input | 8 | Byte from the peripheral side |
| portRxReady | output | 1 | FIFO accepts a peripheral byte |
| dirIn | output | 1 | Effective direction, 1 = input |
| fifoFull | output | 1 | FIFO holds 16 bytes |
| fifoEmpty | output | 1 | FIFO holds no byte |
| serviceIntr | output | 1 | Threshold service flag |
| ackIn | input | 1 | Acknowledge input |
| ackIntr | output | 1 | One-cycle pulse on an acknowledge rising edge |

## Verification
The FIFO is driven four ways. Test mode is filled past capacity and drained past empty, which separates dropped writes and repeated reads from stalls or corruption. Compatibility mode is held with ready low and then released, which shows that host reads and inbound bytes cannot disturb a forward queue. ECP mode is run with both direction values, so that an inbound queue read by the host can be told apart from an outbound one drained by the port. The service flag is stepped one entry at a time across both thresholds, and a mode rewrite after a non-zero read shows whether the flush also clears the repeated byte.

// File: rtl/ppModeFifoPkg.sv
package ppModeFifoPkg;
  localparam logic [2:0] MODE_BASIC  = 3'b000;
  localparam logic [2:0] MODE_COMPAT = 3'b010;
  localparam logic [2:0] MODE_ECP    = 3'b011;
  localparam logic [2:0] MODE_TEST   = 3'b110;

  typedef struct packed {
    logic push;      // write one byte at the tail
    logic pushPort;  // byte comes from the peripheral side
    logic pop;       // drop the head byte
    logic popHost;   // the pop is a host read: save the byte
    logic flush;     // empty the FIFO and clear the saved byte
    logic holdLast;  // empty reads return the saved byte
  } fifoStrobeT;
endpackage

// File: rtl/ppModeFifoDpath.sv
module ppModeFifoDpath
  import ppModeFifoPkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobeT       st,
  input  logic [7:0]       hostWrData,
  input  logic [7:0]       portRxData,
  output logic [7:0]       headData,
  output logic [7:0]       hostRdData,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [7:0]       lastRead;
  logic [7:0]       pushData;

  assign pushData   = st.pushPort ? portRxData : hostWrData;
  assign full       = (count == CNT_W'(DEPTH));
  assign empty      = (count == '0);
  assign headData   = mem[rdPtr];
  assign hostRdData = (empty && st.holdLast) ? lastRead : headData;

  always_ff @(posedge clk) begin
    if (st.push && !st.flush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || st.flush) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      lastRead <= '0;
    end else begin
      if (st.push) wrPtr <= wrPtr + 1'b1;
      if (st.pop) begin
        rdPtr <= rdPtr + 1'b1;
        if (st.popHost) lastRead <= headData;
      end
      case ({st.push, st.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R3
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    full |-> !st.push);
  // R4
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !st.pop);
  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  // R13
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.flush |=> empty);
endmodule

// File: rtl/ppModeFifoCtrl.sv
module ppModeFifoCtrl
  import ppModeFifoPkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int WR_THRESH = 8,
  parameter int RD_THRESH = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeWrEn,
  input  logic [2:0]       modeWrData,
  output logic [2:0]       modeRdData,
  input  logic             ctlWrEn,
  input  logic [7:0]       ctlWrData,
  output logic [7:0]       ctlRdData,
  input  logic             hostWrEn,
  input  logic             hostRdEn,
  output logic             portTxValid,
  input  logic             portTxReady,
  input  logic             portRxValid,
  output logic             portRxReady,
  output logic             dirIn,
  input  logic [CNT_W-1:0] count,
  input  logic             full,
  input  logic             empty,
  output logic             serviceIntr,
  input  logic             ackIn,
  output logic             ackIntr,
  output fifoStrobeT       st
);
  logic [2:0]       modeQ;
  logic [5:0]       ctlQ;
  logic             ackPrev;
  logic             isTest, isCompat, isEcp, forceOut, txActive;
  logic             hostPush, portPush, hostPop, txPop;
  logic [CNT_W-1:0] freeCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ   <= MODE_BASIC;
      ctlQ    <= '0;
      ackPrev <= 1'b0;
      ackIntr <= 1'b0;
    end else begin
      if (modeWrEn) modeQ <= modeWrData;
      if (ctlWrEn)  ctlQ  <= ctlWrData[5:0];
      ackPrev <= ackIn;
      ackIntr <= ackIn && !ackPrev;
    end
  end

  assign modeRdData = modeQ;
  assign ctlRdData  = {2'b00, ctlQ};

  assign isTest   = (modeQ == MODE_TEST);
  assign isCompat = (modeQ == MODE_COMPAT);
  assign isEcp    = (modeQ == MODE_ECP);
  assign forceOut = (modeQ == MODE_BASIC) || isCompat;
  assign dirIn    = !forceOut && ctlQ[5];
  assign txActive = isCompat || (isEcp && !dirIn);

  assign portTxValid = txActive && !empty;
  assign portRxReady = isEcp && dirIn && !full;

  assign hostPush = hostWrEn && !full && (isTest || txActive);
  assign portPush = portRxValid && portRxReady;
  assign hostPop  = hostRdEn && !empty && (isTest || (isEcp && dirIn));
  assign txPop    = portTxValid && portTxReady;

  always_comb begin
    st          = '0;
    st.push     = hostPush || portPush;
    st.pushPort = portPush;
    st.pop      = hostPop || txPop;
    st.popHost  = hostPop;
    st.flush    = modeWrEn;
    st.holdLast = isTest;
  end

  assign freeCnt     = CNT_W'(DEPTH) - count;
  assign serviceIntr = dirIn ? (count >= CNT_W'(RD_THRESH))
                             : (freeCnt >= CNT_W'(WR_THRESH));

  // R6
  forced_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((modeRdData == MODE_BASIC) || (modeRdData == MODE_COMPAT)) |-> !dirIn);
  // R7
  test_port_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeRdData == MODE_TEST) |-> (!portTxValid && !portRxReady));
  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackIn) |=> ackIntr);
  // R11
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackIntr |=> !ackIntr);
  // R12
  ctl_high_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlRdData[7:6] == 2'b00);
endmodule

// File: rtl/ppModeFifo.sv
module ppModeFifo
  import ppModeFifoPkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int WR_THRESH = 8,
  parameter int RD_THRESH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeWrEn,
  input  logic [2:0] modeWrData,
  output logic [2:0] modeRdData,
  input  logic       ctlWrEn,
  input  logic [7:0] ctlWrData,
  output logic [7:0] ctlRdData,
  input  logic       hostWrEn,
  input  logic [7:0] hostWrData,
  input  logic       hostRdEn,
  output logic [7:0] hostRdData,
  output logic       portTxValid,
  output logic [7:0] portTxData,
  input  logic       portTxReady,
  input  logic       portRxValid,
  input  logic [7:0] portRxData,
  output logic       portRxReady,
  output logic       dirIn,
  output logic       fifoFull,
  output logic       fifoEmpty,
  output logic       serviceIntr,
  input  logic       ackIn,
  output logic       ackIntr
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  fifoStrobeT       st;
  logic [CNT_W-1:0] count;

  ppModeFifoCtrl #(.DEPTH(DEPTH), .WR_THRESH(WR_THRESH), .RD_THRESH(RD_THRESH)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .modeWrEn(modeWrEn), .modeWrData(modeWrData), .modeRdData(modeRdData),
    .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData), .ctlRdData(ctlRdData),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn),
    .portTxValid(portTxValid), .portTxReady(portTxReady),
    .portRxValid(portRxValid), .portRxReady(portRxReady),
    .dirIn(dirIn), .count(count), .full(fifoFull), .empty(fifoEmpty),
    .serviceIntr(serviceIntr), .ackIn(ackIn), .ackIntr(ackIntr), .st(st)
  );

  ppModeFifoDpath #(.DEPTH(DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .st(st),
    .hostWrData(hostWrData), .portRxData(portRxData),
    .headData(portTxData), .hostRdData(hostRdData),
    .count(count), .full(fifoFull), .empty(fifoEmpty)
  );
endmodule

// File: tb/ppModeFifo_tb_top.sv
module ppModeFifo_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWrEn = 1'b0, ctlWrEn = 1'b0, hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [2:0] modeWrData = '0;
  logic [7:0] ctlWrData = '0, hostWrData = '0, portRxData = '0;
  logic portTxReady = 1'b0, portRxValid = 1'b0, ackIn = 1'b0;
  logic [2:0] modeRdData;
  logic [7:0] ctlRdData, hostRdData, portTxData;
  logic portTxValid, portRxReady, dirIn, fifoFull, fifoEmpty, serviceIntr, ackIntr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppModeFifo dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setMode(input logic [2:0] m);
    modeWrEn = 1'b1; modeWrData = m; tick(); modeWrEn = 1'b0;
  endtask

  task automatic setCtl(input logic [7:0] v);
    ctlWrEn = 1'b1; ctlWrData = v; tick(); ctlWrEn = 1'b0;
  endtask

  task automatic hostWrite(input logic [7:0] d);
    hostWrEn = 1'b1; hostWrData = d; tick(); hostWrEn = 1'b0;
  endtask

  task automatic hostRead(output logic [7:0] d);
    hostRdEn = 1'b1; #1; d = hostRdData; tick(); hostRdEn = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 empty", fifoEmpty, 1);
    chk("R1 full", fifoFull, 0);
    chk("R1 mode", modeRdData, 0);
    chk("R1 ctl", ctlRdData, 0);
    chk("R1 service", serviceIntr, 1);
    chk("R1 ack", ackIntr, 0);
  endtask

  task automatic testTestMode();
    logic [7:0] d;
    setMode(3'b110);
    setCtl(8'h20);
    chk("R6 dir follows bit in test mode", dirIn, 1);
    setCtl(8'h00);
    for (int i = 0; i < 16; i++) begin
      hostWrite(8'hA0 + 8'(i));
      if (i == 0) begin
        chk("R7 tx idle", portTxValid, 0);
        chk("R7 rx idle", portRxReady, 0);
        chk("R7 head shown", portTxData, 8'hA0);
      end
    end
    chk("R5 full at 16", fifoFull, 1);
    chk("R5 not empty", fifoEmpty, 0);
    hostWrite(8'h55);
    chk("R3 still full", fifoFull, 1);
    chk("R7 tx idle when full", portTxValid, 0);
    setCtl(8'h20);
    for (int i = 0; i < 16; i++) begin
      hostRead(d);
      chk("R2 order", d, 8'hA0 + 8'(i));
      if (i == 0) chk("R5 not full after read", fifoFull, 0);
    end
    chk("R3 dropped byte absent", fifoEmpty, 1);
    hostRead(d);
    chk("R4 repeat last", d, 8'hAF);
    hostRead(d);
    chk("R4 repeat again", d, 8'hAF);
    chk("R5 empty after repeats", fifoEmpty, 1);
    hostWrite(8'h31);
    hostRead(d);
    chk("R4 pointer unmoved", d, 8'h31);
  endtask

  task automatic testThresholds();
    logic [7:0] d;
    setMode(3'b110);
    setCtl(8'h00);
    for (int i = 0; i < 8; i++) hostWrite(8'(i));
    chk("R10 free 8 out", serviceIntr, 1);
    hostWrite(8'h08);
    chk("R10 free 7 out", serviceIntr, 0);
    setCtl(8'h20);
    chk("R10 held 9 in", serviceIntr, 1);
    hostRead(d);
    chk("R10 held 8 in", serviceIntr, 1);
    hostRead(d);
    chk("R10 held 7 in", serviceIntr, 0);
  endtask

  task automatic testCompat();
    logic [7:0] d;
    setMode(3'b010);
    setCtl(8'h20);
    chk("R6 compat forced out", dirIn, 0);
    chk("R12 readback", ctlRdData, 8'h20);
    hostWrite(8'h11); hostWrite(8'h22); hostWrite(8'h33);
    chk("R8 tx valid", portTxValid, 1);
    chk("R8 head", portTxData, 8'h11);
    hostRead(d);
    chk("R8 host read ignored", portTxData, 8'h11);
    chk("R8 rx ready low", portRxReady, 0);
    portRxValid = 1'b1; portRxData = 8'h99; tick(); portRxValid = 1'b0;
    chk("R8 head after rx", portTxData, 8'h11);
    portTxReady = 1'b1;
    chk("R8 drain 0", portTxData, 8'h11); tick();
    chk("R8 drain 1", portTxData, 8'h22); tick();
    chk("R8 drain 2", portTxData, 8'h33); tick();
    portTxReady = 1'b0;
    chk("R8 drained empty", fifoEmpty, 1);
    chk("R8 valid low when empty", portTxValid, 0);
  endtask

  task automatic testEcp();
    logic [7:0] d;
    setMode(3'b011);
    setCtl(8'h20);
    chk("R6 ecp dir in", dirIn, 1);
    chk("R9 rx ready", portRxReady, 1);
    portRxValid = 1'b1;
    portRxData = 8'hC1; tick();
    portRxData = 8'hC2; tick();
    portRxData = 8'hC3; tick();
    portRxValid = 1'b0;
    chk("R9 tx idle inbound", portTxValid, 0);
    hostWrite(8'hEE);
    for (int i = 0; i < 3; i++) begin
      hostRead(d);
      chk("R9 inbound order", d, 8'hC1 + 8'(i));
    end
    chk("R9 host write ignored", fifoEmpty, 1);
    setCtl(8'h00);
    chk("R6 ecp dir out", dirIn, 0);
    hostWrite(8'h5A);
    chk("R9 outbound valid", portTxValid, 1);
    chk("R9 outbound data", portTxData, 8'h5A);
    portTxReady = 1'b1; tick(); portTxReady = 1'b0;
    chk("R9 outbound drained", fifoEmpty, 1);
  endtask

  task automatic testFlush();
    logic [7:0] d;
    setMode(3'b110);
    hostWrite(8'h01); hostWrite(8'h02); hostWrite(8'h03);
    hostRead(d);
    chk("R2 first", d, 8'h01);
    setMode(3'b110);
    chk("R13 flushed", fifoEmpty, 1);
    hostRead(d);
    chk("R13 last cleared", d, 8'h00);
  endtask

  task automatic testCtlBits();
    setCtl(8'hFF);
    chk("R12 upper bits zero", ctlRdData, 8'h3F);
    setCtl(8'h00);
  endtask

  task automatic testAck();
    ackIn = 1'b1;
    chk("R11 not yet", ackIntr, 0);
    tick();
    chk("R11 pulse", ackIntr, 1);
    tick();
    chk("R11 one cycle", ackIntr, 0);
    tick();
    chk("R11 held high no pulse", ackIntr, 0);
    ackIn = 1'b0; tick();
    chk("R11 falling no pulse", ackIntr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTestMode();
    testThresholds();
    testCompat();
    testEcp();
    testFlush();
    testCtlBits();
    testAck();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule